// File: doc/BRIEF.md
# Session Inventoried-Flag Manager

This block keeps the per-tag selection state that an inventory protocol for passive tags depends on. It holds one two-valued inventoried flag for each of four sessions, plus a selected flag. Decoded Select commands force either the selected flag or one chosen session's inventoried flag. Decoded Query commands are tested against that state. A successful test opens an inventory round bound to the Query's session. When the tag is later singulated, an invert request flips the flag of that bound session and no other.

Command demodulation, mask comparison against tag memory and flag persistence timing sit outside the block. Every input is a single-cycle strobe with its fields alongside. Each strobe is taken on the edge where it is high. The block has no back-pressure and never stalls a command. Results appear on registered outputs one cycle after the strobe.

Top module: `sess_flag_mgr`

## Requirements
- R1: After reset, sl_flag is 0, inv_flags[0] is 0 (A), inv_flags[3:1] take the INIT_FLAGS parameter bits (default all A), and qry_done is 0.
- R2: The flag encoding is A = 0 and B = 1, and inv_flags bit i carries session i.
- R3: A Select with sel_kind = 1 sets inv_flags[sel_sess] to sel_value on the next cycle and leaves the other sessions' flags and sl_flag unchanged.
- R4: A Select with sel_kind = 0 sets sl_flag to sel_value on the next cycle and leaves every inventoried flag unchanged.
- R5: One cycle after qry_valid, qry_done is 1 and qry_match is 1 exactly when two conditions both hold. First, qry_target equals inv_flags[qry_sess]. Second, qry_sel agrees with sl_flag: 00 and 01 accept either value, 10 needs sl_flag 0, and 11 needs sl_flag 1. The test uses the state from before any Select issued in that same cycle.
- R6: A matching Query opens a round bound to qry_sess. A Query that does not match closes any open round.
- R7: invert_req while a round is open flips the bound session's flag on the next cycle and closes the round. invert_req with no open round changes nothing.
- R8: When Select and invert_req arrive in the same cycle, the Select is applied and the invert is discarded. The round stays open.
- R9: When qry_valid and invert_req arrive in the same cycle, the Query is processed and the invert is discarded.
- R10: Only a Select can change a flag of a session that is not bound to the open round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_valid | input | 1 | Select command strobe |
| sel_kind | input | 1 | 0: act on selected flag, 1: act on an inventoried flag |
| sel_sess | input | 2 | Session addressed by an inventoried-flag Select |
| sel_value | input | 1 | Value written (SL: 1 asserted; inventoried: 0 A, 1 B) |
| qry_valid | input | 1 | Query command strobe |
| qry_sess | input | 2 | Session named by the Query |
| qry_target | input | 1 | Flag value the Query targets (0 A, 1 B) |
| qry_sel | input | 2 | Selected-flag condition of the Query |
| invert_req | input | 1 | Tag singulated; invert the bound session's flag |
| qry_done | output | 1 | Query result is valid this cycle |
| qry_match | output | 1 | Query matched the tag |
| inv_flags | output | 4 | Inventoried flag per session |
| sl_flag | output | 1 | Selected flag |

## Verification
Queries are tried with each of the four sel codes against both selected-flag values. The targets used both agree and disagree with the named session's flag. This separates a fault in the flag comparison from a fault in the SL condition. Rounds are opened on sessions 0 and 2 and then inverted, and all four flags are checked afterwards. A flip of the wrong session or of a bystander session would show there. Collisions of Select with invert, and of Query with invert, show whether the invert was dropped or applied. A following invert then shows whether the round survived the collision.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
  localparam int unsigned SEL_CODE_W = 2;

  typedef enum logic [SEL_CODE_W-1:0] {
    SELC_ANY0  = 2'b00,
    SELC_ANY1  = 2'b01,
    SELC_CLEAR = 2'b10,
    SELC_SET   = 2'b11
  } sel_cond_e;

  function automatic logic sel_cond_ok(input logic [SEL_CODE_W-1:0] code, input logic sl);
    case (code)
      SELC_CLEAR: sel_cond_ok = ~sl;
      SELC_SET:   sel_cond_ok = sl;
      default:    sel_cond_ok = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/sfm_flag_bank.sv
module sfm_flag_bank #(
  parameter int unsigned NS = 4,
  parameter logic [NS-1:0] INIT_FLAGS = '0,
  localparam int unsigned SW = $clog2(NS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_sess,
  input  logic          wr_val,
  input  logic          flip_en,
  input  logic [SW-1:0] flip_sess,
  output logic [NS-1:0] flags
);
  for (genvar i = 0; i < NS; i++) begin : g_sess
    localparam logic RST_V = (i == 0) ? 1'b0 : INIT_FLAGS[i];
    always_ff @(posedge clk) begin
      if (!rst_n)
        flags[i] <= RST_V;
      else if (wr_en && wr_sess == SW'(i))
        flags[i] <= wr_val;
      else if (flip_en && flip_sess == SW'(i))
        flags[i] <= ~flags[i];
    end
  end
endmodule

// File: rtl/sfm_query_eval.sv
module sfm_query_eval #(
  parameter int unsigned NS = 4,
  localparam int unsigned SW = $clog2(NS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          q_valid,
  input  logic [SW-1:0] q_sess,
  input  logic          q_target,
  input  logic [1:0]    q_sel,
  input  logic [NS-1:0] flags,
  input  logic          sl,
  output logic          hit,
  output logic          done_q,
  output logic          match_q
);
  import sfm_pkg::*;

  always_comb hit = (flags[q_sess] == q_target) && sel_cond_ok(q_sel, sl);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      match_q <= 1'b0;
    end else begin
      done_q  <= q_valid;
      match_q <= q_valid && hit;
    end
  end
endmodule

// File: rtl/sfm_round_track.sv
module sfm_round_track #(
  parameter int unsigned NS = 4,
  localparam int unsigned SW = $clog2(NS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          q_valid,
  input  logic          q_hit,
  input  logic [SW-1:0] q_sess,
  input  logic          sel_busy,
  input  logic          inv_req,
  output logic          open_q,
  output logic [SW-1:0] sess_q,
  output logic          flip
);
  always_comb flip = inv_req && open_q && !sel_busy && !q_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      sess_q <= '0;
    end else if (q_valid) begin
      open_q <= q_hit;
      sess_q <= q_sess;
    end else if (flip) begin
      open_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sess_flag_mgr.sv
module sess_flag_mgr #(
  parameter int unsigned NS = 4,
  parameter logic [NS-1:0] INIT_FLAGS = '0,
  localparam int unsigned SW = $clog2(NS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_valid,
  input  logic          sel_kind,
  input  logic [SW-1:0] sel_sess,
  input  logic          sel_value,
  input  logic          qry_valid,
  input  logic [SW-1:0] qry_sess,
  input  logic          qry_target,
  input  logic [1:0]    qry_sel,
  input  logic          invert_req,
  output logic          qry_done,
  output logic          qry_match,
  output logic [NS-1:0] inv_flags,
  output logic          sl_flag
);
  logic          hit;
  logic          round_open;
  logic [SW-1:0] round_sess;
  logic          flip;

  always_ff @(posedge clk) begin
    if (!rst_n)
      sl_flag <= 1'b0;
    else if (sel_valid && !sel_kind)
      sl_flag <= sel_value;
  end

  sfm_flag_bank #(.NS(NS), .INIT_FLAGS(INIT_FLAGS)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(sel_valid && sel_kind), .wr_sess(sel_sess), .wr_val(sel_value),
    .flip_en(flip), .flip_sess(round_sess), .flags(inv_flags)
  );

  sfm_query_eval #(.NS(NS)) u_eval (
    .clk(clk), .rst_n(rst_n), .q_valid(qry_valid), .q_sess(qry_sess),
    .q_target(qry_target), .q_sel(qry_sel), .flags(inv_flags), .sl(sl_flag),
    .hit(hit), .done_q(qry_done), .match_q(qry_match)
  );

  sfm_round_track #(.NS(NS)) u_round (
    .clk(clk), .rst_n(rst_n), .q_valid(qry_valid), .q_hit(hit), .q_sess(qry_sess),
    .sel_busy(sel_valid), .inv_req(invert_req),
    .open_q(round_open), .sess_q(round_sess), .flip(flip)
  );
endmodule

// File: rtl/sess_flag_mgr_chk.sv
module sess_flag_mgr_chk #(
  parameter int unsigned NS = 4,
  localparam int unsigned SW = $clog2(NS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel_valid,
  input logic          sel_kind,
  input logic [SW-1:0] sel_sess,
  input logic          sel_value,
  input logic          qry_valid,
  input logic [1:0]    qry_sel,
  input logic          invert_req,
  input logic          qry_done,
  input logic          qry_match,
  input logic [NS-1:0] inv_flags,
  input logic          sl_flag,
  input logic          round_open,
  input logic [SW-1:0] round_sess
);
  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_n |=> (inv_flags[0] == 1'b0 && !sl_flag && !qry_done)); // R1

  AST_SEL_INV_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && sel_kind) |=> inv_flags[$past(sel_sess)] == $past(sel_value)); // R3

  AST_SEL_SL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && !sel_kind) |=> (sl_flag == $past(sel_value) && $stable(inv_flags))); // R4

  AST_SEL_COND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (qry_valid && qry_sel == 2'b11 && !sl_flag) |=> (qry_done && !qry_match)); // R5

  AST_INVERT_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (invert_req && round_open && !sel_valid && !qry_valid) |=>
      (inv_flags[$past(round_sess)] != $past(inv_flags[round_sess]) && !round_open)); // R7

  AST_SEL_BEATS_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && !sel_kind && invert_req) |=> $stable(inv_flags)); // R8

  for (genvar i = 0; i < NS; i++) begin : g_iso
    AST_ISOLATE: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_valid && !(round_open && round_sess == SW'(i))) |=> $stable(inv_flags[i])); // R10
  end
endmodule

bind sess_flag_mgr sess_flag_mgr_chk #(.NS(NS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_valid(sel_valid), .sel_kind(sel_kind),
  .sel_sess(sel_sess), .sel_value(sel_value), .qry_valid(qry_valid), .qry_sel(qry_sel),
  .invert_req(invert_req), .qry_done(qry_done), .qry_match(qry_match),
  .inv_flags(inv_flags), .sl_flag(sl_flag), .round_open(round_open), .round_sess(round_sess)
);

// File: tb/sim_sess_flag_mgr.sv
module sim_sess_flag_mgr;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_valid = 0, sel_kind = 0, sel_value = 0;
  logic [1:0] sel_sess = 0;
  logic qry_valid = 0, qry_target = 0;
  logic [1:0] qry_sess = 0, qry_sel = 0;
  logic invert_req = 0;
  logic qry_done, qry_match, sl_flag;
  logic [3:0] inv_flags;

  int total = 0;
  int bad = 0;

  logic [3:0] e_flags;
  logic e_sl, e_open;
  logic [1:0] e_sess;

  always #5 clk = ~clk;

  sess_flag_mgr u0 (
    .clk(clk), .rst_n(rst_n), .sel_valid(sel_valid), .sel_kind(sel_kind),
    .sel_sess(sel_sess), .sel_value(sel_value), .qry_valid(qry_valid),
    .qry_sess(qry_sess), .qry_target(qry_target), .qry_sel(qry_sel),
    .invert_req(invert_req), .qry_done(qry_done), .qry_match(qry_match),
    .inv_flags(inv_flags), .sl_flag(sl_flag)
  );

  task automatic check(input string tag, input string what, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // One command cycle: model the requirements, drive, sample at the next negedge.
  task automatic step(input string tag,
                      input logic sv, input logic sk, input logic [1:0] ss, input logic sval,
                      input logic qv, input logic [1:0] qs, input logic qt, input logic [1:0] qc,
                      input logic iv);
    logic cond, m;
    logic [3:0] nf;
    logic nsl;
    cond = (qc == 2'b10) ? !e_sl : (qc == 2'b11) ? e_sl : 1'b1;
    m = (e_flags[qs] == qt) && cond;
    nf = e_flags;
    nsl = e_sl;
    if (sv && sk) nf[ss] = sval;
    else if (sv) nsl = sval;
    if (qv) begin
      e_open = m;
      e_sess = qs;
    end else if (iv && !sv && e_open) begin
      nf[e_sess] = ~nf[e_sess];
      e_open = 1'b0;
    end
    e_flags = nf;
    e_sl = nsl;
    sel_valid = sv; sel_kind = sk; sel_sess = ss; sel_value = sval;
    qry_valid = qv; qry_sess = qs; qry_target = qt; qry_sel = qc;
    invert_req = iv;
    @(negedge clk);
    sel_valid = 0; qry_valid = 0; invert_req = 0;
    check(tag, "inv_flags", inv_flags, e_flags);
    check(tag, "sl_flag", {3'b0, sl_flag}, {3'b0, e_sl});
    check(tag, "qry_done", {3'b0, qry_done}, {3'b0, qv});
    if (qv) check(tag, "qry_match", {3'b0, qry_match}, {3'b0, m});
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    e_flags = 4'b0000; e_sl = 0; e_open = 0; e_sess = 0;
    check("R1", "inv_flags", inv_flags, 4'b0000);
    check("R1", "sl_flag", {3'b0, sl_flag}, 4'b0);
    check("R1", "qry_done", {3'b0, qry_done}, 4'b0);
  endtask

  task automatic t_select;
    step("R3", 1, 1, 2'd2, 1, 0, 0, 0, 0, 0);
    step("R2", 1, 1, 2'd3, 1, 0, 0, 0, 0, 0);
    step("R3", 1, 1, 2'd2, 0, 0, 0, 0, 0, 0);
    step("R4", 1, 0, 2'd1, 1, 0, 0, 0, 0, 0);
    step("R4", 1, 0, 2'd3, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_query;
    step("R5", 0, 0, 0, 0, 1, 2'd3, 1, 2'b00, 0);
    step("R5", 0, 0, 0, 0, 1, 2'd3, 0, 2'b01, 0);
    step("R5", 0, 0, 0, 0, 1, 2'd0, 0, 2'b11, 0);
    step("R5", 0, 0, 0, 0, 1, 2'd0, 0, 2'b10, 0);
    step("R4", 1, 0, 0, 1, 0, 0, 0, 0, 0);
    step("R5", 0, 0, 0, 0, 1, 2'd0, 0, 2'b10, 0);
    step("R5", 0, 0, 0, 0, 1, 2'd1, 0, 2'b11, 0);
    step("R5", 1, 1, 2'd1, 1, 1, 2'd1, 0, 2'b11, 0);
  endtask

  task automatic t_invert;
    step("R6", 0, 0, 0, 0, 1, 2'd2, 0, 2'b11, 0);
    step("R7", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    step("R7", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    step("R6", 0, 0, 0, 0, 1, 2'd0, 0, 2'b00, 0);
    step("R6", 0, 0, 0, 0, 1, 2'd0, 1, 2'b00, 0);
    step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_collide;
    step("R6", 0, 0, 0, 0, 1, 2'd0, 0, 2'b01, 0);
    step("R8", 1, 0, 0, 0, 0, 0, 0, 0, 1);
    step("R8", 1, 1, 2'd0, 1, 0, 0, 0, 0, 1);
    step("R8", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    step("R6", 0, 0, 0, 0, 1, 2'd3, 1, 2'b00, 0);
    step("R9", 0, 0, 0, 0, 1, 2'd3, 1, 2'b00, 1);
    step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_select();
    t_query();
    t_invert();
    t_collide();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule